// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the SDRAM command bus from reset until the memory is usable, and keeps it refreshed afterwards. After reset it holds the bus at NOP for a programmable settling time. It then walks a fixed script: precharge of every bank, eight auto-refresh commands, a mode register write and, when enabled, an extended mode register write for low-power parts. When the script is done it raises `ready` and never lowers it again until the next reset.

From then on a free-running interval counter, loaded from `cfg_ref_period`, raises `ref_req` each time it expires. An external arbiter answers with `ref_grant` once the bus is quiet. The sequencer then drives one auto-refresh and waits out the row-cycle time before it accepts another grant.

All spacings are counted in clock cycles. Each command is on the bus for a single cycle, and NOP is driven in every other cycle. Configuration inputs must stay stable from reset until `ready`.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While `rst` is high, `sd_cke`, `ready` and `ref_req` are 0 and the bus carries NOP. Command codes are given as {cs_n,ras_n,cas_n,we_n}: NOP=0111, precharge=0010, auto-refresh=0001, mode write=0000. `sd_cke` is 1 after every clock edge that has `rst` low.
- R2: Count the clock edges with `rst` low as 1, 2, 3 and so on, and let P be `cfg_pwr_wait`. The bus shows NOP after edges 1..P. After edge P+1 it shows precharge-all, with `sd_addr[10]`=1, every other address bit 0 and `sd_ba`=0.
- R3: The first of exactly eight auto-refresh commands comes tRP=`cfg_trp` cycles after the precharge. Each following one comes tRC=`cfg_trc` cycles after the one before it, with address and bank 0.
- R4: A mode write comes tRC cycles after the eighth auto-refresh. It has `sd_ba`=0, `sd_addr[6:4]`=`cfg_cas_lat`, `sd_addr[2:0]`=`cfg_burst_len` and all other address bits 0. No mode write appears once `ready` is high.
- R5: When `cfg_ext_en`=1, a second mode write follows the first after TMRD (2) cycles. It carries `sd_ba`=2'b10 and `sd_addr`=`cfg_ext_val`. When `cfg_ext_en`=0 this command is absent.
- R6: `ready` rises TMRD cycles after the last mode write and stays high.
- R7: A value of 0 in `cfg_trp` or `cfg_trc` acts as 1.
- R8: `ref_req` rises `cfg_ref_period` cycles after the edge that raised `ready`, and again each `cfg_ref_period` cycles after that, whether or not a refresh was granted.
- R9: `ref_req` stays high until it is granted. If `ref_grant` is high at an edge where the request is pending and no refresh wait is running, an auto-refresh appears after that edge and `ref_req` drops with it.
- R10: `ref_grant` has no effect during initialisation or when no request is pending. After a granted auto-refresh, only NOP is driven for tRC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pwr_wait | input | PWR_W | NOP cycles after reset before the first command |
| cfg_trp | input | TIM_W | Precharge-to-next-command spacing |
| cfg_trc | input | TIM_W | Spacing after each auto-refresh |
| cfg_cas_lat | input | 3 | CAS latency written by the mode write |
| cfg_burst_len | input | 3 | Burst-length code written by the mode write |
| cfg_ext_en | input | 1 | Enables the extended mode write |
| cfg_ext_val | input | ADDR_W | Address value of the extended mode write |
| cfg_ref_period | input | REF_W | Refresh interval in cycles |
| ref_grant | input | 1 | Arbiter grant for a pending refresh |
| ref_req | output | 1 | Refresh pending |
| ready | output | 1 | Initialisation complete |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |

## Verification
The assertions assume three things about the inputs. The configuration does not change between reset and `ready`. `cfg_cas_lat` and `cfg_burst_len` stay constant while a mode write is on the bus. The arbiter may hold `ref_grant` high at any time, including during initialisation. The stimulus sets every configuration value while reset is held and leaves it untouched for the whole run. It drives `ref_grant` high through the script and before the first request, so a grant that has no effect is exercised. It then holds the grant low for a short window, so a pending request has to wait.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // Command codes as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_AREF,
    ST_LMR,
    ST_EMR,
    ST_FINAL,
    ST_RUN
  } seq_state_e;

endpackage

// File: rtl/sdr_gap_timer.sv
// Down counter that spaces commands; zero means the next step may issue.
module sdr_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= rst_val;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sdr_refresh_timer.sv
// Interval counter with a single sticky pending flag.
module sdr_refresh_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] period,
  input  logic         take,
  output logic         pend
);

  logic         running;
  logic [W-1:0] rc;
  logic [W-1:0] reload;

  // A zero period behaves as a period of one cycle
  assign reload = (period == '0) ? '0 : period - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      rc      <= '0;
      pend    <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      rc      <= reload;
      pend    <= 1'b0;
    end else if (running) begin
      if (rc == '0) begin
        rc   <= reload;
        pend <= 1'b1;
      end else begin
        rc <= rc - 1'b1;
        if (take) begin
          pend <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sdr_init_fsm.sv
// Script walker: picks the next command when the gap timer reaches zero
// and registers the whole command bus.
module sdr_init_fsm
  import sdr_seq_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              BANK_W    = 2,
  parameter int              TIM_W     = 4,
  parameter int              GAP_W     = 16,
  parameter int              TMRD      = 2,
  parameter int              INIT_AREF = 8,
  parameter logic [BANK_W-1:0] EXT_BA  = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gap_zero,
  input  logic [TIM_W-1:0]  cfg_trp,
  input  logic [TIM_W-1:0]  cfg_trc,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_ext_en,
  input  logic [ADDR_W-1:0] cfg_ext_val,
  input  logic              ref_pend,
  input  logic              ref_grant,
  output logic              gap_load,
  output logic [GAP_W-1:0]  gap_val,
  output logic              ref_start,
  output logic              ref_take,
  output logic              ready,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int AR_W = (INIT_AREF > 1) ? $clog2(INIT_AREF) : 1;
  localparam logic [AR_W-1:0] AR_LAST = AR_W'(INIT_AREF - 1);
  localparam logic [GAP_W-1:0] MRD_GAP = GAP_W'(TMRD - 1);

  seq_state_e        state, nxt_state;
  logic [AR_W-1:0]   ar_cnt, nxt_ar;
  sdr_cmd_e          nxt_cmd;
  logic [BANK_W-1:0] nxt_ba;
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_ready;
  logic [TIM_W-1:0]  trp_e, trc_e;
  logic [GAP_W-1:0]  trp_gap, trc_gap;

  assign trp_e   = (cfg_trp == '0) ? TIM_W'(1) : cfg_trp;
  assign trc_e   = (cfg_trc == '0) ? TIM_W'(1) : cfg_trc;
  assign trp_gap = GAP_W'(trp_e) - GAP_W'(1);
  assign trc_gap = GAP_W'(trc_e) - GAP_W'(1);

  always_comb begin
    nxt_state = state;
    nxt_ar    = ar_cnt;
    nxt_cmd   = CMD_NOP;
    nxt_ba    = '0;
    nxt_addr  = '0;
    nxt_ready = ready;
    gap_load  = 1'b0;
    gap_val   = '0;
    ref_start = 1'b0;
    ref_take  = 1'b0;
    if (gap_zero) begin
      case (state)
        ST_PWR: begin
          nxt_cmd      = CMD_PRE;
          nxt_addr[10] = 1'b1;
          gap_load     = 1'b1;
          gap_val      = trp_gap;
          nxt_state    = ST_AREF;
        end
        ST_AREF: begin
          nxt_cmd  = CMD_AREF;
          gap_load = 1'b1;
          gap_val  = trc_gap;
          if (ar_cnt == AR_LAST) begin
            nxt_state = ST_LMR;
            nxt_ar    = '0;
          end else begin
            nxt_ar = ar_cnt + 1'b1;
          end
        end
        ST_LMR: begin
          nxt_cmd       = CMD_MRS;
          nxt_addr[6:4] = cfg_cas_lat;
          nxt_addr[2:0] = cfg_burst_len;
          gap_load      = 1'b1;
          gap_val       = MRD_GAP;
          nxt_state     = cfg_ext_en ? ST_EMR : ST_FINAL;
        end
        ST_EMR: begin
          nxt_cmd   = CMD_MRS;
          nxt_ba    = EXT_BA;
          nxt_addr  = cfg_ext_val;
          gap_load  = 1'b1;
          gap_val   = MRD_GAP;
          nxt_state = ST_FINAL;
        end
        ST_FINAL: begin
          nxt_ready = 1'b1;
          ref_start = 1'b1;
          nxt_state = ST_RUN;
        end
        ST_RUN: begin
          if (ref_pend && ref_grant) begin
            nxt_cmd  = CMD_AREF;
            ref_take = 1'b1;
            gap_load = 1'b1;
            gap_val  = trc_gap;
          end
        end
        default: nxt_state = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_PWR;
      ar_cnt <= '0;
      ready  <= 1'b0;
      cke    <= 1'b0;
      cmd    <= CMD_NOP;
      ba     <= '0;
      addr   <= '0;
    end else begin
      state  <= nxt_state;
      ar_cnt <= nxt_ar;
      ready  <= nxt_ready;
      cke    <= 1'b1;
      cmd    <= nxt_cmd;
      ba     <= nxt_ba;
      addr   <= nxt_addr;
    end
  end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int TIM_W  = 4,
  parameter int PWR_W  = 16,
  parameter int REF_W  = 16,
  parameter int TMRD   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PWR_W-1:0]  cfg_pwr_wait,
  input  logic [TIM_W-1:0]  cfg_trp,
  input  logic [TIM_W-1:0]  cfg_trc,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_ext_en,
  input  logic [ADDR_W-1:0] cfg_ext_val,
  input  logic [REF_W-1:0]  cfg_ref_period,
  input  logic              ref_grant,
  output logic              ref_req,
  output logic              ready,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);

  localparam int GAP_W = (PWR_W > TIM_W) ? PWR_W : TIM_W;

  logic             gap_zero;
  logic             gap_load;
  logic [GAP_W-1:0] gap_val;
  logic             ref_start;
  logic             ref_take;
  logic [3:0]       cmd;

  sdr_gap_timer #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .rst_val  (GAP_W'(cfg_pwr_wait)),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  sdr_refresh_timer #(.W(REF_W)) u_ref (
    .clk    (clk),
    .rst    (rst),
    .start  (ref_start),
    .period (cfg_ref_period),
    .take   (ref_take),
    .pend   (ref_req)
  );

  sdr_init_fsm #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .TIM_W  (TIM_W),
    .GAP_W  (GAP_W),
    .TMRD   (TMRD)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .gap_zero      (gap_zero),
    .cfg_trp       (cfg_trp),
    .cfg_trc       (cfg_trc),
    .cfg_cas_lat   (cfg_cas_lat),
    .cfg_burst_len (cfg_burst_len),
    .cfg_ext_en    (cfg_ext_en),
    .cfg_ext_val   (cfg_ext_val),
    .ref_pend      (ref_req),
    .ref_grant     (ref_grant),
    .gap_load      (gap_load),
    .gap_val       (gap_val),
    .ref_start     (ref_start),
    .ref_take      (ref_take),
    .ready         (ready),
    .cke           (sd_cke),
    .cmd           (cmd),
    .ba            (sd_ba),
    .addr          (sd_addr)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BANK_W-1:0] sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [2:0]        cfg_cas_lat,
  input logic [2:0]        cfg_burst_len,
  input logic              ready,
  input logic              ref_req,
  input logic              ref_grant
);

  logic [3:0] bus;
  assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  p_cke_low_in_reset_r1: assert property (@(posedge clk)
    rst |=> !sd_cke);

  p_mode_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (bus == 4'b0000 && sd_ba == '0) |->
      (sd_addr[6:4] == cfg_cas_lat && sd_addr[2:0] == cfg_burst_len));

  p_no_mode_in_run_r4: assert property (@(posedge clk) disable iff (rst)
    ready |-> bus != 4'b0000);

  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_grant) |=> ref_req);

  p_no_unrequested_ref_r10: assert property (@(posedge clk) disable iff (rst)
    (ready && !ref_req) |=> bus != 4'b0001);

  p_ref_then_nop_r10: assert property (@(posedge clk) disable iff (rst)
    (ready && bus == 4'b0001) |=> bus == 4'b0111);

endmodule

bind sdram_init_refresh_seq sdr_seq_checker #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W)
) u_sdr_seq_checker (
  .clk           (clk),
  .rst           (rst),
  .sd_cke        (sd_cke),
  .sd_cs_n       (sd_cs_n),
  .sd_ras_n      (sd_ras_n),
  .sd_cas_n      (sd_cas_n),
  .sd_we_n       (sd_we_n),
  .sd_ba         (sd_ba),
  .sd_addr       (sd_addr),
  .cfg_cas_lat   (cfg_cas_lat),
  .cfg_burst_len (cfg_burst_len),
  .ready         (ready),
  .ref_req       (ref_req),
  .ref_grant     (ref_grant)
);

// File: tb/test_sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_init_refresh_seq;

  localparam int ADDR_W = 12;
  localparam int BANK_W = 2;
  localparam int TIM_W  = 4;
  localparam int PWR_W  = 16;
  localparam int REF_W  = 16;
  localparam int TMRD   = 2;
  localparam int RPER   = 12;
  localparam int HOLD   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PWR_W-1:0]  cfg_pwr_wait = '0;
  logic [TIM_W-1:0]  cfg_trp = '0;
  logic [TIM_W-1:0]  cfg_trc = '0;
  logic [2:0]        cfg_cas_lat = 3'd3;
  logic [2:0]        cfg_burst_len = 3'd0;
  logic              cfg_ext_en = 1'b0;
  logic [ADDR_W-1:0] cfg_ext_val = '0;
  logic [REF_W-1:0]  cfg_ref_period = REF_W'(RPER);
  logic              ref_grant = 1'b0;
  logic              ref_req, ready, sd_cke;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BANK_W-1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_init_refresh_seq #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .TIM_W(TIM_W),
    .PWR_W(PWR_W), .REF_W(REF_W), .TMRD(TMRD)
  ) i_sdram_init_refresh_seq (
    .clk(clk), .rst(rst), .cfg_pwr_wait(cfg_pwr_wait), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .cfg_cas_lat(cfg_cas_lat), .cfg_burst_len(cfg_burst_len),
    .cfg_ext_en(cfg_ext_en), .cfg_ext_val(cfg_ext_val),
    .cfg_ref_period(cfg_ref_period), .ref_grant(ref_grant), .ref_req(ref_req),
    .ready(ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;

  function automatic logic [17:0] word(input logic [3:0] c,
                                       input logic [1:0] b,
                                       input logic [11:0] a);
    return {c, b, a};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Per-run schedule, all in edge numbers counted from reset release
  int t_pre, trp_e, trc_e, t_lmr, t_emr, t_rdy;

  task automatic expect_at(input int k, output logic [17:0] w, output string tag);
    bool_init: begin end
    w   = word(C_NOP, 2'b00, 12'h000);
    tag = (k < t_rdy) ? "R3" : "R10";
    if (k <= t_pre) tag = "R2";
    if (k == t_pre) w = word(C_PRE, 2'b00, 12'h400);
    for (int i = 0; i < 8; i++) begin
      if (k == t_pre + trp_e + i * trc_e) begin
        w   = word(C_REF, 2'b00, 12'h000);
        tag = "R3";
      end
    end
    if (k == t_lmr) begin
      w   = word(C_MRS, 2'b00, {5'b0, cfg_cas_lat, 1'b0, cfg_burst_len});
      tag = "R4";
    end
    if (cfg_ext_en && k == t_emr) begin
      w   = word(C_MRS, 2'b10, cfg_ext_val);
      tag = "R5";
    end
    if (k == t_rdy + RPER + HOLD + 1 || k == t_rdy + 2 * RPER + 1) begin
      w   = word(C_REF, 2'b00, 12'h000);
      tag = "R9";
    end
    if ((cfg_trp == 0 || cfg_trc == 0) && k < t_rdy && k > t_pre) tag = "R7";
  endtask

  task automatic run_cfg(input int p, input int trp, input int trc, input bit ext, input int seed);
    logic [17:0] w_exp, w_act;
    string       tag;
    bit          req_exp, gnt;
    @(negedge clk);
    rst            = 1'b1;
    cfg_pwr_wait   = PWR_W'(p);
    cfg_trp        = TIM_W'(trp);
    cfg_trc        = TIM_W'(trc);
    cfg_cas_lat    = 3'(seed % 8);
    cfg_burst_len  = 3'((seed * 3 + 1) % 8);
    cfg_ext_en     = ext;
    cfg_ext_val    = 12'h0A5 ^ 12'(seed * 37);
    ref_grant      = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sd_cke == 1'b0 && ready == 1'b0 && ref_req == 1'b0 &&
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP,
          "R1 reset state", {sd_cke, ready, ref_req, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n},
          {3'b000, C_NOP});
    trp_e = (trp == 0) ? 1 : trp;
    trc_e = (trc == 0) ? 1 : trc;
    t_pre = p + 1;
    t_lmr = t_pre + trp_e + 8 * trc_e;
    t_emr = t_lmr + TMRD;
    t_rdy = (ext ? t_emr : t_lmr) + TMRD;
    rst   = 1'b0;
    for (int k = 1; k <= t_rdy + 2 * RPER + 3; k++) begin
      gnt = !(k >= t_rdy + RPER + 1 && k <= t_rdy + RPER + HOLD);
      ref_grant = gnt;
      @(posedge clk);
      @(negedge clk);
      expect_at(k, w_exp, tag);
      w_act = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
      check(w_act == w_exp, tag, 32'(w_act), 32'(w_exp));
      check(sd_cke == 1'b1, "R1 cke", 32'(sd_cke), 32'd1);
      check(ready == (k >= t_rdy), "R6 ready", 32'(ready), 32'(k >= t_rdy));
      req_exp = (k >= t_rdy + RPER && k <= t_rdy + RPER + HOLD) ||
                (k == t_rdy + 2 * RPER);
      check(ref_req == req_exp, (k > t_rdy + RPER) ? "R9 req" : "R8 req",
            32'(ref_req), 32'(req_exp));
    end
  endtask

  initial begin
    int seed = 0;
    for (int p = 0; p <= 5; p += 5)
      for (int trp = 0; trp <= 3; trp++)
        for (int trc = 0; trc <= 3; trc++)
          for (int ext = 0; ext <= 1; ext++) begin
            run_cfg(p, trp, trc, ext[0], seed);
            seed++;
          end
    run_cfg(7, 3, 9, 1'b1, 99);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule